// File: doc/BRIEF.md
# Time-Multiplexed 32-Channel Readout Sequencer

This block paces the digitisation of 32 analog channels spread over four 8-channel groups. Each group has one 10-bit ADC clocked at half the 40 MHz system rate and an input selector made from two 4-way analog switches with joined outputs. The block drives each group's switch address, its one-hot bank enable and its ADC clock. It then gathers the ADC results into 21-bit link words, one word per system cycle and sixteen words per 400 ns frame.

Two groups hold the even channels and two hold the odd ones. The even groups convert on one phase of the 20 MHz ADC clock and the odd groups on the other. The word assembly therefore alternates between the even pair and the odd pair on every system cycle. Word n carries channel n and channel n+16. The last word of each frame carries a sync flag. A board-enable input holds all of the control logic in reset while it is low. A pipeline-latency parameter lines the captured results up with the channel they belong to, so the first valid word after release is always word 0.

Top module: `readout_sequencer`

## Requirements
- R1: The link word places the channel n result in bits 9:0, the channel n+16 result in bits 19:10 and the sync flag in bit 20. Even-numbered words take their data from groups 0 and 2, and odd-numbered words from groups 1 and 3.
- R2: Once the first valid word has appeared, a valid word appears on every cycle while the block is enabled. The index n runs 0,1,...,15 and then wraps, giving a frame period of 16 cycles.
- R3: The sync flag is 1 only in the word with n = 15 and 0 in every other word.
- R4: After release from hold, the first valid word is n = 0. It appears in the (2·ADC_LAT+2)-th cycle counted from the enabling cycle, and it carries data sampled in the new run. An enable that lasts fewer cycles than this produces no valid word.
- R5: While rst is high or board_en is low, word_valid_o is 0, word_o is 0 and all ADC clocks are low. On release, sampling restarts from slot 0.
- R6: Each ADC clock toggles on every cycle while running, which is half the system rate. Groups 0 and 2 are high together, and groups 1 and 3 are high on the opposite phase. Groups 0 and 2 are high in the first running cycle.
- R7: Group g serves channels (g/2)·16 + 2·slot + (g mod 2) for slot 0..7, in ascending slot order. Slot j drives address j[1:0]. The bank enable is 2'b01 for j < 4 and 2'b10 for j ≥ 4, and is one-hot at all times.
- R8: A group's address and bank enable are unchanged during the cycle before each rising edge of its ADC clock. They move to the next slot in the cycle right after that rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 40 MHz system clock |
| rst | input | 1 | Synchronous active-high reset |
| board_en | input | 1 | Board enable; low holds the sequencer in reset |
| adc_data_i | input | 40 | Four 10-bit ADC result buses, group g at bits 10g+9:10g |
| mux_addr_o | output | 8 | 2-bit analog switch address per group, group g at bits 2g+1:2g |
| bank_en_o | output | 8 | One-hot bank enable per group, group g at bits 2g+1:2g |
| adc_clk_o | output | 4 | ADC conversion clock per group |
| word_o | output | 21 | Link word: sync, high-half result, low-half result |
| word_valid_o | output | 1 | High when word_o holds a valid word |

## Verification
A wrong frame counter or word index shows up at the ports within one cycle as a word whose channel fields do not match the expected sequence, or as a sync flag in the wrong slot. A wrong switch address, bank or pipeline alignment appears within one frame plus the ADC latency, because the bench's ADC model encodes both the channel number and the frame count in every sample. A hold that fails to clear state shows up in the first word after release, which must be word 0 and must carry frame 0 data.

// File: rtl/rdo_pkg.sv
`timescale 1ns/1ps
package rdo_pkg;
    localparam int GROUPS  = 4;
    localparam int ADC_W   = 10;
    localparam int SLOTS   = 8;
    localparam int BANKS   = 2;
    localparam int SLOT_W  = $clog2(SLOTS);
    localparam int ADDR_W  = SLOT_W - 1;
    localparam int WORDS   = GROUPS * SLOTS / 2;
    localparam int SEQ_W   = $clog2(WORDS);
    localparam int LINK_W  = 2 * ADC_W + 1;

    typedef struct packed {
        logic             sync;
        logic [ADC_W-1:0] hi;
        logic [ADC_W-1:0] lo;
    } link_word_t;

    // slot presented by a group's selector for the current sequence step:
    // odd groups convert on odd steps, even groups on even steps, and the
    // selector advances right after its own conversion
    function automatic logic [SLOT_W-1:0] slot_for(input logic [SEQ_W-1:0] s,
                                                   input logic odd);
        logic [SEQ_W-1:0] t;
        t = odd ? s : s + SEQ_W'(1);
        return SLOT_W'(t >> 1);
    endfunction

    function automatic logic [BANKS-1:0] bank_for(input logic [SLOT_W-1:0] slot);
        logic [BANKS-1:0] b;
        b = '0;
        b[slot[SLOT_W-1]] = 1'b1;
        return b;
    endfunction
endpackage

// File: rtl/rdo_seq_timer.sv
`timescale 1ns/1ps
module rdo_seq_timer
    import rdo_pkg::*;
#(
    parameter int ADC_LAT = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             board_en,
    output logic             running,
    output logic [SEQ_W-1:0] seq,
    output logic             capture,
    output logic [SEQ_W-1:0] word_idx
);
    localparam int WARM   = 2 * ADC_LAT;
    localparam int WARM_W = $clog2(WARM + 1);

    logic [WARM_W-1:0] warm;

    always_ff @(posedge clk) begin
        if (rst || !board_en) begin
            running <= 1'b0;
            seq     <= '0;
            warm    <= '0;
        end else begin
            running <= 1'b1;
            if (running) begin
                seq <= seq + SEQ_W'(1);
                if (warm != WARM_W'(WARM)) warm <= warm + WARM_W'(1);
            end
        end
    end

    assign capture  = running && (warm == WARM_W'(WARM));
    assign word_idx = seq - SEQ_W'(WARM % WORDS);

    assert_seq_wrap_R2: assert property (@(posedge clk) disable iff (rst)
        (running && board_en && seq == SEQ_W'(WORDS - 1)) |=> (seq == '0));
endmodule

// File: rtl/rdo_group_ctrl.sv
`timescale 1ns/1ps
module rdo_group_ctrl
    import rdo_pkg::*;
#(
    parameter bit ODD = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              running,
    input  logic [SEQ_W-1:0]  seq,
    output logic [ADDR_W-1:0] addr,
    output logic [BANKS-1:0]  bank,
    output logic              adc_clk
);
    logic [SLOT_W-1:0] slot;

    always_comb begin
        slot    = slot_for(seq, ODD);
        addr    = slot[ADDR_W-1:0];
        bank    = bank_for(slot);
        adc_clk = running && (seq[0] == ODD);
    end

    assert_select_settled_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(adc_clk) |-> ($stable(addr) && $stable(bank)));

    assert_bank_onehot_R7: assert property (@(posedge clk) disable iff (rst)
        $countones(bank) == 1);
endmodule

// File: rtl/rdo_word_packer.sv
`timescale 1ns/1ps
module rdo_word_packer
    import rdo_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    hold,
    input  logic                    capture,
    input  logic                    parity,
    input  logic [SEQ_W-1:0]        word_idx,
    input  logic [GROUPS*ADC_W-1:0] adc_data,
    output link_word_t              word,
    output logic                    valid
);
    localparam int HALF = GROUPS / 2;

    logic [ADC_W-1:0] bus [GROUPS];
    link_word_t       next_word;

    for (genvar g = 0; g < GROUPS; g++) begin : g_unpack
        assign bus[g] = adc_data[g*ADC_W +: ADC_W];
    end

    always_comb begin
        next_word.lo   = parity ? bus[1] : bus[0];
        next_word.hi   = parity ? bus[HALF + 1] : bus[HALF];
        next_word.sync = (word_idx == SEQ_W'(WORDS - 1));
    end

    always_ff @(posedge clk) begin
        if (hold || !capture) begin
            word  <= '0;
            valid <= 1'b0;
        end else begin
            word  <= next_word;
            valid <= 1'b1;
        end
    end

    assert_first_index_R4: assert property (@(posedge clk) disable iff (rst)
        (!hold && capture && !valid) |-> (word_idx == '0));

    assert_parity_match_R1: assert property (@(posedge clk) disable iff (rst)
        capture |-> (parity == word_idx[0]));
endmodule

// File: rtl/readout_sequencer.sv
`timescale 1ns/1ps
module readout_sequencer
    import rdo_pkg::*;
#(
    parameter int ADC_LAT = 1
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     board_en,
    input  logic [GROUPS*ADC_W-1:0]  adc_data_i,
    output logic [GROUPS*ADDR_W-1:0] mux_addr_o,
    output logic [GROUPS*BANKS-1:0]  bank_en_o,
    output logic [GROUPS-1:0]        adc_clk_o,
    output logic [LINK_W-1:0]        word_o,
    output logic                     word_valid_o
);
    logic             running;
    logic             capture;
    logic [SEQ_W-1:0] seq;
    logic [SEQ_W-1:0] word_idx;
    link_word_t       word;

    rdo_seq_timer #(.ADC_LAT(ADC_LAT)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .board_en (board_en),
        .running  (running),
        .seq      (seq),
        .capture  (capture),
        .word_idx (word_idx)
    );

    for (genvar g = 0; g < GROUPS; g++) begin : g_group
        rdo_group_ctrl #(.ODD(1'(g % 2))) u_ctrl (
            .clk     (clk),
            .rst     (rst),
            .running (running),
            .seq     (seq),
            .addr    (mux_addr_o[g*ADDR_W +: ADDR_W]),
            .bank    (bank_en_o[g*BANKS +: BANKS]),
            .adc_clk (adc_clk_o[g])
        );
    end

    rdo_word_packer u_packer (
        .clk      (clk),
        .rst      (rst),
        .hold     (rst || !board_en),
        .capture  (capture),
        .parity   (seq[0]),
        .word_idx (word_idx),
        .adc_data (adc_data_i),
        .word     (word),
        .valid    (word_valid_o)
    );

    assign word_o = word;

    assert_quiet_hold_R5: assert property (@(posedge clk) disable iff (rst)
        !board_en |=> (!word_valid_o && adc_clk_o == '0 && word_o == '0));

    assert_valid_steady_R2: assert property (@(posedge clk) disable iff (rst)
        (word_valid_o && board_en) |=> word_valid_o);

    assert_sync_spacing_R3: assert property (@(posedge clk) disable iff (rst)
        (word_valid_o && word_o[LINK_W-1]) |=> !word_o[LINK_W-1]);

    assert_clk_phase_R6: assert property (@(posedge clk) disable iff (rst)
        word_valid_o |-> (adc_clk_o[0] != adc_clk_o[1]));
endmodule

// File: tb/readout_sequencer_tb.sv
`timescale 1ns/1ps
module readout_sequencer_tb;
    localparam int CLK_PERIOD = 25;
    localparam int LAT        = 1;
    localparam int NG         = 4;
    localparam int DW         = 10;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            board_en = 1'b0;
    logic [NG*DW-1:0] adc_data = '0;
    logic [NG*2-1:0] mux_addr;
    logic [NG*2-1:0] bank_en;
    logic [NG-1:0]   adc_clk;
    logic [20:0]     word;
    logic            word_valid;

    int vectors = 0;
    int misses  = 0;
    int total_words = 0;
    int total_syncs = 0;
    int exp_words = 0;
    int conv [NG];
    logic [DW-1:0] pipe [NG][LAT];
    logic [NG-1:0] prev_clk = '0;
    logic [NG*2-1:0] prev_addr = '0;
    logic [NG*2-1:0] prev_bank = '0;
    bit prev_run = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    readout_sequencer #(.ADC_LAT(LAT)) u_dut (
        .clk          (clk),
        .rst          (rst),
        .board_en     (board_en),
        .adc_data_i   (adc_data),
        .mux_addr_o   (mux_addr),
        .bank_en_o    (bank_en),
        .adc_clk_o    (adc_clk),
        .word_o       (word),
        .word_valid_o (word_valid)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (!ok) begin
            misses++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    initial begin
        for (int g = 0; g < NG; g++) begin
            conv[g] = 0;
            for (int k = 0; k < LAT; k++) pipe[g][k] = '0;
        end
    end

    // ADC models and port monitor, evaluated mid-cycle
    always @(negedge clk) begin
        logic all_low;
        logic [2:0] slot;
        logic [4:0] ch;
        logic [20:0] exp_w;
        int n;
        int f;
        all_low = (adc_clk == '0);
        if (all_low) begin
            exp_words = 0;
            for (int g = 0; g < NG; g++) conv[g] = 0;
            chk(!word_valid, "R5 valid while clocks stopped", {31'd0, word_valid}, 0);
        end else begin
            chk(adc_clk[0] == adc_clk[2] && adc_clk[1] == adc_clk[3] && adc_clk[0] != adc_clk[1],
                "R6 clock phases", {28'd0, adc_clk}, 32'h5);
            if (prev_run)
                chk(adc_clk != prev_clk, "R6 half-rate toggle", {28'd0, adc_clk}, {28'd0, ~prev_clk});
            else
                chk(adc_clk == 4'b0101, "R6 first running phase", {28'd0, adc_clk}, 32'h5);
        end
        for (int g = 0; g < NG; g++) begin
            chk($countones(bank_en[2*g +: 2]) == 1, "R7 bank one-hot", {30'd0, bank_en[2*g +: 2]}, 0);
            if (adc_clk[g] && !prev_clk[g]) begin
                chk(mux_addr[2*g +: 2] == prev_addr[2*g +: 2] && bank_en[2*g +: 2] == prev_bank[2*g +: 2],
                    "R8 select settled before sample", {28'd0, mux_addr[2*g +: 2], bank_en[2*g +: 2]},
                    {28'd0, prev_addr[2*g +: 2], prev_bank[2*g +: 2]});
                slot = {bank_en[2*g+1], mux_addr[2*g +: 2]};
                chk(slot == 3'(conv[g] % 8) && bank_en[2*g +: 2] == (slot[2] ? 2'b10 : 2'b01),
                    "R7 slot order", {29'd0, slot}, conv[g] % 8);
                ch = 5'((g / 2) * 16 + 2 * slot + (g % 2));
                adc_data[g*DW +: DW] = pipe[g][LAT-1];
                for (int k = LAT - 1; k > 0; k--) pipe[g][k] = pipe[g][k-1];
                pipe[g][0] = {5'((conv[g] / 8) % 32), ch};
                conv[g]++;
            end
        end
        if (word_valid) begin
            n = exp_words % 16;
            f = (exp_words / 16) % 32;
            exp_w = {(n == 15), 5'(f), 5'(n + 16), 5'(f), 5'(n)};
            chk(word == exp_w, "R1 word fields and order", {11'd0, word}, {11'd0, exp_w});
            chk(word[20] == (n == 15), "R3 sync placement", {31'd0, word[20]}, {31'd0, n == 15});
            exp_words++;
            total_words++;
            if (word[20]) total_syncs++;
        end else if (!all_low && exp_words > 0) begin
            chk(0, "R2 gap in word stream", 0, 1);
        end
        prev_run  = !all_low;
        prev_clk  = adc_clk;
        prev_addr = mux_addr;
        prev_bank = bank_en;
    end

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic t_reset_state();
        rst = 1'b1;
        board_en = 1'b1;
        repeat (4) step();
        chk(!word_valid, "R5 valid in reset", {31'd0, word_valid}, 0);
        chk(word == '0, "R5 word in reset", {11'd0, word}, 0);
        chk(adc_clk == '0, "R5 adc clocks in reset", {28'd0, adc_clk}, 0);
        chk(bank_en == 8'h55 && mux_addr == '0, "R5 selects at slot 0", {16'd0, mux_addr, bank_en}, 32'h0055);
    endtask

    task automatic t_first_word();
        int k;
        k = 0;
        while (!word_valid && k < 40) begin
            step();
            k++;
        end
        chk(k == 2 * LAT + 2, "R4 first word latency", k, 2 * LAT + 2);
        chk(word[4:0] == 5'd0 && word[14:10] == 5'd16 && word[9:5] == 5'd0 && word[19:15] == 5'd0,
            "R4 first word is n=0 of new run", {11'd0, word}, 32'h4000);
    endtask

    task automatic t_stream(input int frames);
        int w0;
        int s0;
        w0 = total_words;
        s0 = total_syncs;
        repeat (16 * frames) step();
        chk(total_words - w0 == 16 * frames, "R2 one word per cycle", total_words - w0, 16 * frames);
        chk(total_syncs - s0 == frames, "R3 one sync per frame", total_syncs - s0, frames);
    endtask

    task automatic t_hold_mid_frame();
        repeat (7) step();
        board_en = 1'b0;
        step();
        for (int i = 0; i < 12; i++) begin
            chk(!word_valid && word == '0 && adc_clk == '0, "R5 quiet while disabled",
                {10'd0, word_valid, word}, 0);
            step();
        end
        board_en = 1'b1;
        t_first_word();
        t_stream(2);
    endtask

    task automatic t_reset_mid_frame();
        repeat (5) step();
        rst = 1'b1;
        step();
        chk(!word_valid && adc_clk == '0, "R5 quiet in reset pulse", {27'd0, word_valid, adc_clk}, 0);
        rst = 1'b0;
        t_first_word();
        t_stream(1);
    endtask

    task automatic t_short_enable();
        int seen;
        board_en = 1'b0;
        repeat (3) step();
        board_en = 1'b1;
        step();
        step();
        board_en = 1'b0;
        seen = 0;
        repeat (8) begin
            step();
            if (word_valid) seen++;
        end
        chk(seen == 0, "R4 short enable yields no word", seen, 0);
        board_en = 1'b1;
        t_first_word();
        t_stream(1);
    endtask

    initial begin
        t_reset_state();
        rst = 1'b0;
        t_first_word();
        t_stream(3);
        t_hold_mid_frame();
        t_reset_mid_frame();
        t_short_enable();
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!finished) begin
            vectors++;
            misses++;
            $display("FAIL R2 watchdog actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end
endmodule